// File: doc/BRIEF.md
# Pipeline Slot Timer and Stall Controller

This block decides how many system clock cycles each pipeline slot lasts in a small in-order pipeline that can issue two integer instructions per slot. At the start of every slot it samples which of the five stages (fetch, decode, execute, memory access, write-back) hold an instruction. It also samples the fetch and memory-access cycle demands, whether the prefetch buffer already holds the instruction decode wants, and the class tags of the two issue lanes. The slot length is the largest demand among the active stages. Every shorter stage waits behind that demand.

The controller loads an internal down-counter with the computed length. It raises a one-cycle advance pulse on the final cycle of the slot and samples the inputs for the next slot at the end of that cycle. While a slot runs, every active stage sees its hold bit set, except in the final cycle. A grant for the second issue lane is given for the whole slot only when both lanes carry integer-class tags. Any other pairing leaves the second instruction waiting for a later slot.

Top module: `slot_timer_top`

## Requirements
- R1: The slot length in cycles equals the largest demand among the stages active in that slot. Decode, execute and write-back each demand 1 cycle, and a slot with no active stage (stage_act all zero) lasts 1 cycle.
- R2: The fetch demand equals fetch_lat only when decode is active (stage_act bit 1) and pbuf_hit is low. Otherwise fetch latency has no effect on the slot length.
- R3: When the memory-access stage is active (stage_act bit 3), its demand is mem_lat, with a value of 0 treated as 1. When that stage is inactive, mem_lat has no effect.
- R4: slot_adv is high for exactly one cycle, the last cycle of each slot. The inputs for the next slot are sampled on the clock edge that ends that cycle.
- R5: stage_hold has the same bit order as stage_act (bit 0 fetch, 1 decode, 2 execute, 3 memory access, 4 write-back). Each bit is high on every cycle of a slot except the last, for the stages active in that slot. It is low otherwise.
- R6: lane_b_grant is high for the whole slot when lane_b_req is high and both cls_a and cls_b are 2'b00 (integer). It is low for any other class code or without a request, so no stage ever holds more than two instructions.
- R7: A synchronous active-high reset clears the counter, the latched stage valid bits and all outputs. With no active stage at release, slot_adv is high in the first cycle after reset is released.
- R8: Input changes during a slot, after its first edge, do not alter that slot's length or grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_act | input | 5 | Stage occupancy for the next slot (0 fetch, 1 decode, 2 execute, 3 memory access, 4 write-back) |
| fetch_lat | input | LAT_W | Cycles the pending instruction memory access needs |
| mem_lat | input | LAT_W | Cycles the memory-access stage needs |
| pbuf_hit | input | 1 | Prefetch buffer holds the instruction decode needs |
| cls_a | input | 2 | Class tag of issue lane A (2'b00 integer) |
| cls_b | input | 2 | Class tag of issue lane B (2'b00 integer) |
| lane_b_req | input | 1 | Lane B has an instruction to issue |
| slot_adv | output | 1 | One-cycle pulse on the last cycle of a slot |
| stage_hold | output | 5 | Per-stage hold, same bit order as stage_act |
| lane_b_grant | output | 1 | Lane B may issue in the current slot |

## Verification
The assertions assume that all inputs for a slot are valid on the edge that ends the previous slot's advance cycle, or on the first edge after reset is released. They also assume that reset starts high at time zero. The bench drives each new set of inputs on the falling edge of an advance cycle, so every slot is loaded from a complete, settled set. Inputs change mid-slot only in the test that checks they are ignored. The random stimulus keeps latencies inside the LAT_W range, so the reference maximum never exceeds the counter's width.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int NSTG  = 5;
  localparam int ST_IF = 0;
  localparam int ST_ID = 1;
  localparam int ST_EX = 2;
  localparam int ST_MA = 3;
  localparam int ST_WB = 4;

  typedef enum logic [1:0] {
    CLS_INT  = 2'b00,
    CLS_FP   = 2'b01,
    CLS_SYS  = 2'b10,
    CLS_MISC = 2'b11
  } iclass_e;
endpackage

// File: rtl/slot_len_calc.sv
module slot_len_calc
  import slot_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             dec_act,
  input  logic             mem_act,
  input  logic             pbuf_hit,
  input  logic [LAT_W-1:0] fetch_lat,
  input  logic [LAT_W-1:0] mem_lat,
  output logic [LAT_W-1:0] slot_len
);
  localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

  logic [LAT_W-1:0] demand [NSTG];

  // per-stage cycle demand; only fetch and memory access vary
  for (genvar g = 0; g < NSTG; g++) begin : g_dem
    if (g == ST_IF) begin : g_fetch
      assign demand[g] = (dec_act && !pbuf_hit) ? fetch_lat : ONE;
    end else if (g == ST_MA) begin : g_mem
      assign demand[g] = mem_act ? mem_lat : ONE;
    end else begin : g_fixed
      assign demand[g] = ONE;
    end
  end

  // longest demand wins; floor of one cycle covers empty slots and zero latencies
  always_comb begin
    slot_len = ONE;
    for (int i = 0; i < NSTG; i++) begin
      if (demand[i] > slot_len) slot_len = demand[i];
    end
  end
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAT_W-1:0] slot_len,
  output logic             load,
  output logic [LAT_W-1:0] cnt_q,
  output logic             slot_adv_q
);
  logic [LAT_W-1:0] cnt_d;

  // zero after reset or one on the last cycle: take the next slot's length
  assign load  = (cnt_q <= LAT_W'(1));
  assign cnt_d = load ? slot_len : cnt_q - LAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      slot_adv_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      slot_adv_q <= (cnt_d == LAT_W'(1));
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > LAT_W'(1)) |=> (cnt_q == LAT_W'($past(cnt_q) - LAT_W'(1))));  // R4
endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import slot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       lane_b_req,
  input  logic [1:0] cls_a,
  input  logic [1:0] cls_b,
  output logic       grant_q
);
  logic pair_int;

  assign pair_int = lane_b_req && (cls_a == CLS_INT) && (cls_b == CLS_INT);

  always_ff @(posedge clk) begin
    if (rst)       grant_q <= 1'b0;
    else if (load) grant_q <= pair_int;
  end
endmodule

// File: rtl/slot_timer_top.sv
module slot_timer_top
  import slot_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTG-1:0]  stage_act,
  input  logic [LAT_W-1:0] fetch_lat,
  input  logic [LAT_W-1:0] mem_lat,
  input  logic             pbuf_hit,
  input  logic [1:0]       cls_a,
  input  logic [1:0]       cls_b,
  input  logic             lane_b_req,
  output logic             slot_adv,
  output logic [NSTG-1:0]  stage_hold,
  output logic             lane_b_grant
);
  logic [LAT_W-1:0] slot_len;
  logic [LAT_W-1:0] cnt_q;
  logic             load;
  logic [NSTG-1:0]  act_q;
  logic [NSTG-1:0]  act_sel;
  logic [NSTG-1:0]  hold_q;
  logic             long_d;

  slot_len_calc #(.LAT_W(LAT_W)) u_len (
    .dec_act   (stage_act[ST_ID]),
    .mem_act   (stage_act[ST_MA]),
    .pbuf_hit  (pbuf_hit),
    .fetch_lat (fetch_lat),
    .mem_lat   (mem_lat),
    .slot_len  (slot_len)
  );

  slot_counter #(.LAT_W(LAT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .slot_len   (slot_len),
    .load       (load),
    .cnt_q      (cnt_q),
    .slot_adv_q (slot_adv)
  );

  issue_gate u_issue (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .lane_b_req (lane_b_req),
    .cls_a      (cls_a),
    .cls_b      (cls_b),
    .grant_q    (lane_b_grant)
  );

  // stage valid bits latched per slot; hold stays high while more than one cycle is left
  assign act_sel = load ? stage_act : act_q;
  assign long_d  = load ? (slot_len > LAT_W'(1)) : (cnt_q > LAT_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      hold_q <= '0;
    end else begin
      if (load) act_q <= stage_act;
      hold_q <= act_sel & {NSTG{long_d}};
    end
  end

  assign stage_hold = hold_q;

  AST_HOLD_END: assert property (@(posedge clk) disable iff (rst)
    slot_adv |-> (stage_hold == '0));  // R5
  AST_FETCH_COVER: assert property (@(posedge clk) disable iff (rst)
    (load && stage_act[ST_ID] && !pbuf_hit) |=> (cnt_q >= $past(fetch_lat)));  // R2
  AST_MEM_COVER: assert property (@(posedge clk) disable iff (rst)
    (load && stage_act[ST_MA]) |=> (cnt_q >= $past(mem_lat)));  // R3
  AST_GRANT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > LAT_W'(1)) |=> $stable(lane_b_grant));  // R6
endmodule

// File: tb/slot_timer_top_tb.sv
module slot_timer_top_tb_top;
  typedef struct packed {
    logic [4:0] act;
    logic [3:0] fl;
    logic [3:0] ml;
    logic       hit;
    logic [1:0] ca;
    logic [1:0] cb;
    logic       req;
    logic [3:0] len;
    logic       gr;
  } vec_t;

  // act bits: 0 fetch, 1 decode, 2 execute, 3 mem access, 4 write-back
  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{5'b00000, 4'd5,  4'd5,  1'b0, 2'd0, 2'd0, 1'b1, 4'd1,  1'b1},  // R1 empty slot
    '{5'b00010, 4'd4,  4'd0,  1'b0, 2'd0, 2'd1, 1'b1, 4'd4,  1'b0},  // R2 miss
    '{5'b00010, 4'd4,  4'd0,  1'b1, 2'd0, 2'd0, 1'b0, 4'd1,  1'b0},  // R2 hit
    '{5'b01000, 4'd0,  4'd3,  1'b0, 2'd0, 2'd0, 1'b1, 4'd3,  1'b1},  // R3
    '{5'b11110, 4'd2,  4'd6,  1'b0, 2'd2, 2'd0, 1'b1, 4'd6,  1'b0},  // R1 mem longest
    '{5'b11111, 4'd7,  4'd2,  1'b0, 2'd0, 2'd0, 1'b1, 4'd7,  1'b1},  // R1 fetch longest
    '{5'b01000, 4'd0,  4'd0,  1'b0, 2'd3, 2'd3, 1'b1, 4'd1,  1'b0},  // R3 zero clamp
    '{5'b00010, 4'd0,  4'd0,  1'b0, 2'd0, 2'd0, 1'b1, 4'd1,  1'b1},  // R2 zero fetch
    '{5'b11111, 4'd15, 4'd15, 1'b0, 2'd1, 2'd0, 1'b1, 4'd15, 1'b0},  // R1 max width
    '{5'b00100, 4'd9,  4'd9,  1'b0, 2'd0, 2'd0, 1'b1, 4'd1,  1'b1}   // R2/R3 inactive
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] stage_act = '0;
  logic [3:0] fetch_lat = '0;
  logic [3:0] mem_lat = '0;
  logic       pbuf_hit = 1'b0;
  logic [1:0] cls_a = '0;
  logic [1:0] cls_b = '0;
  logic       lane_b_req = 1'b0;
  logic       slot_adv;
  logic [4:0] stage_hold;
  logic       lane_b_grant;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  slot_timer_top #(.LAT_W(4)) dut_i (
    .clk(clk), .rst(rst), .stage_act(stage_act), .fetch_lat(fetch_lat),
    .mem_lat(mem_lat), .pbuf_hit(pbuf_hit), .cls_a(cls_a), .cls_b(cls_b),
    .lane_b_req(lane_b_req), .slot_adv(slot_adv), .stage_hold(stage_hold),
    .lane_b_grant(lane_b_grant)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic [3:0] fl, input logic [3:0] ml,
                       input logic hit, input logic [1:0] ca, input logic [1:0] cb,
                       input logic req);
    stage_act = a; fetch_lat = fl; mem_lat = ml; pbuf_hit = hit;
    cls_a = ca; cls_b = cb; lane_b_req = req;
  endtask

  function automatic int ref_len(input logic [4:0] a, input logic [3:0] fl,
                                 input logic [3:0] ml, input logic hit);
    int m = 1;
    if (a[1] && !hit && int'(fl) > m) m = int'(fl);
    if (a[3] && int'(ml) > m) m = int'(ml);
    return m;
  endfunction

  // called on the falling edge of an advance cycle, right after driving
  task automatic run_slot(input int exp_len, input logic exp_gr, input logic [4:0] exp_act,
                          input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk({tag, " R6 grant"}, int'(lane_b_grant), int'(exp_gr));
        if (exp_len > 1) chk({tag, " R5 hold"}, int'(stage_hold), int'(exp_act));
      end
    end while (!slot_adv && n < 40);
    chk({tag, " R1 length"}, n, exp_len);
    chk({tag, " R4 R5 hold at end"}, int'(stage_hold), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset adv", int'(slot_adv), 0);
    chk("R7 reset hold", int'(stage_hold), 0);
    chk("R7 reset grant", int'(lane_b_grant), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 first adv", int'(slot_adv), 1);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].act, VEC[i].fl, VEC[i].ml, VEC[i].hit, VEC[i].ca, VEC[i].cb, VEC[i].req);
      run_slot(int'(VEC[i].len), VEC[i].gr, VEC[i].act, $sformatf("vec%0d", i));
    end

    // R8: inputs changed after the first edge leave the running slot alone
    begin
      int n = 0;
      drive(5'b01000, 4'd0, 4'd5, 1'b0, 2'd0, 2'd0, 1'b1);
      @(negedge clk);
      n = 1;
      drive(5'b00010, 4'd9, 4'd1, 1'b0, 2'd1, 2'd0, 1'b1);
      while (!slot_adv && n < 40) begin
        @(negedge clk);
        n++;
        if (n == 3) chk("R8 grant kept", int'(lane_b_grant), 1);
      end
      chk("R8 length kept", n, 5);
      run_slot(9, 1'b0, 5'b00010, "R8 next slot");
    end

    // R7: reset in the middle of a long slot
    drive(5'b01000, 4'd0, 4'd9, 1'b0, 2'd0, 2'd0, 1'b1);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R7 mid reset adv", int'(slot_adv), 0);
    chk("R7 mid reset hold", int'(stage_hold), 0);
    chk("R7 mid reset grant", int'(lane_b_grant), 0);
    drive(5'b00000, 4'd0, 4'd0, 1'b0, 2'd0, 2'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 adv after release", int'(slot_adv), 1);

    // random slots against the reference maximum
    for (int k = 0; k < 300; k++) begin
      logic [4:0] a  = 5'($urandom);
      logic [3:0] fl = 4'($urandom);
      logic [3:0] ml = 4'($urandom);
      logic       h  = 1'($urandom);
      logic [1:0] ca = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      logic [1:0] cb = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      logic       rq = 1'($urandom);
      drive(a, fl, ml, h, ca, cb, rq);
      run_slot(ref_len(a, fl, ml, h), rq && ca == 2'd0 && cb == 2'd0, a,
               $sformatf("rand%0d R2 R3", k));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule